// File: doc/BRIEF.md
# Serial Display Command Master with Data/Command Line

The block drives a small display controller over a four-wire mode 0 serial link: chip select, serial clock, data out and data in, plus a separate data/command line. A request carries an opcode, a byte count and a read flag. For a write, the opcode goes out with the data/command line low, then the parameter bytes are pulled one at a time from a byte stream and sent with the line high. For a read, the opcode is followed by clocking in the requested number of response bytes at a slower rate, and each assembled byte is delivered on a byte output strobe. The block can also run a hardware reset sequence on the panel's reset line.

Clock rates come from three half-period parameters counted in system clocks: one for command bytes and short transfers, one for long transfers such as pixel data, and one for reads. Two read opcodes, 0x04 (identity) and 0x09 (status), answer with one dummy clock before the data, so the block clocks in one extra byte and shifts the stream left by one bit.

The controller is a state machine with states IDLE, RST_LO, RST_WAIT, CMD, FETCH, PARAM, RD and END. Transitions: IDLE to RST_LO on a reset request (this has priority); IDLE to CMD on an accepted request; RST_LO to RST_WAIT when the low timer expires; RST_WAIT to IDLE when the wait timer expires; CMD to RD after the opcode of a read, to FETCH after the opcode of a write with parameters, to END after the opcode of a write with none; FETCH to PARAM when a stream byte is taken; PARAM to FETCH while bytes remain, else to END; RD to END after the last raw byte; END to IDLE.

Top module: `dbi_spi_master`

## Requirements
- R1: The data/command line is low for every bit of an opcode byte and high for every bit of a parameter byte; it is high while idle.
- R2: The opcode of a write uses the command half-period; parameter bytes use the command half-period when the count is at most SHORT_MAX (default 64) and the long-transfer half-period when it is larger.
- R3: For a read the opcode and all response bytes use the read half-period with the data/command line low; data in is sampled at each rising clock edge, the output sends zeros during the response, and bytes appear on the byte output in order.
- R4: For a read with opcode 0x04 or 0x09 and count 3 or 4, count+1 raw bytes are clocked and output byte i is raw[i] shifted left by one with bit 7 of raw[i+1] in bit 0.
- R5: A read with count 0, or opcode 0x04/0x09 with a count other than 3 or 4, gives a one-cycle error pulse while busy stays low and chip select never asserts.
- R6: A reset request holds the panel reset line low for RST_LO_CYC cycles, then high for RST_WAIT_CYC cycles with busy high, then pulses the done output for one cycle; no serial activity occurs.
- R7: Chip select falls once per accepted command and stays low from the opcode through the last byte.
- R8: Busy rises on acceptance, is high whenever chip select is low, and falls one cycle after chip select rises.
- R9: Mode 0: the serial clock is low whenever chip select is high, data out changes only while the clock is low, and bytes go out most significant bit first.
- R10: The byte request output is high only in the parameter phase; a write with count 0 sends the opcode alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hwrst_req | input | 1 | Start panel reset sequence (sampled in IDLE) |
| req_valid | input | 1 | Command request (sampled in IDLE) |
| req_op | input | 8 | Opcode |
| req_len | input | LEN_W | Parameter or response byte count |
| req_read | input | 1 | Request is a read |
| tx_data | input | 8 | Parameter byte stream data |
| tx_valid | input | 1 | Parameter byte available |
| tx_ready | output | 1 | Block takes a byte when both are high |
| rx_data | output | 8 | Assembled response byte |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| busy | output | 1 | Command or reset in progress |
| err | output | 1 | Rejected read request pulse |
| rst_done | output | 1 | Reset sequence complete pulse |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_dcx | output | 1 | Data/command select |
| lcd_rst_n | output | 1 | Panel reset, active low |

## Verification
The assertions assume requests and reset requests are offered only while busy is low and each is held for a single accepting cycle, and that the three half-period parameters are at least one. The stimulus raises a request for exactly one cycle after busy has fallen, keeps the byte stream valid with the next byte, and drives data in only from a slave model that changes it after rising clock edges, so sampling never meets a changing input.

// File: rtl/dbi_pkg.sv
package dbi_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_RST_LO, S_RST_WAIT, S_CMD, S_FETCH, S_PARAM, S_RD, S_END
    } dbi_state_e;

    localparam logic [7:0] OP_RD_ID     = 8'h04;
    localparam logic [7:0] OP_RD_STATUS = 8'h09;
endpackage

// File: rtl/dbi_shifter.sv
module dbi_shifter #(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [HALF_W-1:0] half,
    input  logic [7:0]        tx_byte,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              done,
    output logic [7:0]        rx_byte
);
    logic              active_q, hi_q, done_q;
    logic [HALF_W-1:0] cnt_q;
    logic [2:0]        bit_q;
    logic [7:0]        sh_q, rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            hi_q     <= 1'b0;
            done_q   <= 1'b0;
            cnt_q    <= '0;
            bit_q    <= '0;
            sh_q     <= '0;
            rx_q     <= '0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                active_q <= 1'b1;
                hi_q     <= 1'b0;
                cnt_q    <= half - HALF_W'(1);
                bit_q    <= '0;
                sh_q     <= tx_byte;
            end else if (active_q) begin
                if (cnt_q != '0) begin
                    cnt_q <= cnt_q - HALF_W'(1);
                end else begin
                    cnt_q <= half - HALF_W'(1);
                    if (!hi_q) begin
                        hi_q <= 1'b1;
                        rx_q <= {rx_q[6:0], miso};
                    end else begin
                        hi_q <= 1'b0;
                        if (bit_q == 3'd7) begin
                            active_q <= 1'b0;
                            done_q   <= 1'b1;
                        end else begin
                            bit_q <= bit_q + 3'd1;
                            sh_q  <= {sh_q[6:0], 1'b0};
                        end
                    end
                end
            end
        end
    end

    assign sclk    = hi_q;
    assign mosi    = sh_q[7];
    assign done    = done_q;
    assign rx_byte = rx_q;
endmodule

// File: rtl/dbi_rx_align.sv
module dbi_rx_align (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       dummy,
    input  logic       in_stb,
    input  logic [7:0] in_byte,
    output logic       out_stb,
    output logic [7:0] out_byte
);
    logic       have_prev_q, stb_q;
    logic [7:0] prev_q, out_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            have_prev_q <= 1'b0;
            stb_q       <= 1'b0;
            prev_q      <= '0;
            out_q       <= '0;
        end else begin
            stb_q <= 1'b0;
            if (clear) begin
                have_prev_q <= 1'b0;
            end else if (in_stb) begin
                if (!dummy) begin
                    out_q <= in_byte;
                    stb_q <= 1'b1;
                end else begin
                    if (have_prev_q) begin
                        out_q <= {prev_q[6:0], in_byte[7]};
                        stb_q <= 1'b1;
                    end
                    prev_q      <= in_byte;
                    have_prev_q <= 1'b1;
                end
            end
        end
    end

    assign out_stb  = stb_q;
    assign out_byte = out_q;
endmodule

// File: rtl/dbi_spi_master.sv
module dbi_spi_master
    import dbi_pkg::*;
#(
    parameter int LEN_W        = 16,
    parameter int CMD_HALF     = 10,
    parameter int PIX_HALF     = 2,
    parameter int RD_HALF      = 50,
    parameter int SHORT_MAX    = 64,
    parameter int RST_LO_CYC   = 4000000,
    parameter int RST_WAIT_CYC = 24000000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hwrst_req,
    input  logic             req_valid,
    input  logic [7:0]       req_op,
    input  logic [LEN_W-1:0] req_len,
    input  logic             req_read,
    input  logic [7:0]       tx_data,
    input  logic             tx_valid,
    output logic             tx_ready,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    output logic             busy,
    output logic             err,
    output logic             rst_done,
    output logic             spi_sclk,
    output logic             spi_mosi,
    input  logic             spi_miso,
    output logic             spi_cs_n,
    output logic             spi_dcx,
    output logic             lcd_rst_n
);
    localparam int MAXH1  = (CMD_HALF > PIX_HALF) ? CMD_HALF : PIX_HALF;
    localparam int MAXH   = (MAXH1 > RD_HALF) ? MAXH1 : RD_HALF;
    localparam int HALF_W = $clog2(MAXH + 1);
    localparam int MAXT   = (RST_LO_CYC > RST_WAIT_CYC) ? RST_LO_CYC : RST_WAIT_CYC;
    localparam int TMR_W  = $clog2(MAXT + 1);

    dbi_state_e        state_q, state_d;
    logic              go_q, rd_q, dummy_q, clr_q, err_q, done_q;
    logic [7:0]        byte_q;
    logic [HALF_W-1:0] half_q, par_half_q;
    logic [LEN_W-1:0]  len_left_q, raw_left_q;
    logic [TMR_W-1:0]  timer_q;
    logic              sh_done;
    logic [7:0]        sh_rx;
    logic              req_dummy, req_bad;

    assign req_dummy = req_read && (req_op == OP_RD_ID || req_op == OP_RD_STATUS);
    assign req_bad   = req_read && ((req_len == '0) ||
                       (req_dummy && req_len != LEN_W'(3) && req_len != LEN_W'(4)));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (hwrst_req)                  state_d = S_RST_LO;
                else if (req_valid && !req_bad) state_d = S_CMD;
            end
            S_RST_LO:   if (timer_q == '0) state_d = S_RST_WAIT;
            S_RST_WAIT: if (timer_q == '0) state_d = S_IDLE;
            S_CMD: begin
                if (sh_done) begin
                    if (rd_q)                  state_d = S_RD;
                    else if (len_left_q == '0) state_d = S_END;
                    else                       state_d = S_FETCH;
                end
            end
            S_FETCH: if (tx_valid) state_d = S_PARAM;
            S_PARAM: begin
                if (sh_done) state_d = (len_left_q == '0) ? S_END : S_FETCH;
            end
            S_RD:  if (sh_done && raw_left_q == LEN_W'(1)) state_d = S_END;
            S_END: state_d = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            go_q       <= 1'b0;
            rd_q       <= 1'b0;
            dummy_q    <= 1'b0;
            clr_q      <= 1'b0;
            err_q      <= 1'b0;
            done_q     <= 1'b0;
            byte_q     <= '0;
            half_q     <= HALF_W'(CMD_HALF);
            par_half_q <= HALF_W'(CMD_HALF);
            len_left_q <= '0;
            raw_left_q <= '0;
            timer_q    <= '0;
        end else begin
            go_q   <= 1'b0;
            clr_q  <= 1'b0;
            err_q  <= 1'b0;
            done_q <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (hwrst_req) begin
                        timer_q <= TMR_W'(RST_LO_CYC - 1);
                    end else if (req_valid) begin
                        if (req_bad) begin
                            err_q <= 1'b1;
                        end else begin
                            go_q       <= 1'b1;
                            clr_q      <= 1'b1;
                            byte_q     <= req_op;
                            rd_q       <= req_read;
                            dummy_q    <= req_dummy;
                            len_left_q <= req_len;
                            raw_left_q <= req_len + LEN_W'(req_dummy);
                            half_q     <= req_read ? HALF_W'(RD_HALF) : HALF_W'(CMD_HALF);
                            par_half_q <= (req_len > LEN_W'(SHORT_MAX)) ?
                                          HALF_W'(PIX_HALF) : HALF_W'(CMD_HALF);
                        end
                    end
                end
                S_RST_LO: begin
                    if (timer_q == '0) timer_q <= TMR_W'(RST_WAIT_CYC - 1);
                    else               timer_q <= timer_q - TMR_W'(1);
                end
                S_RST_WAIT: begin
                    if (timer_q == '0) done_q  <= 1'b1;
                    else               timer_q <= timer_q - TMR_W'(1);
                end
                S_CMD: begin
                    if (sh_done) begin
                        if (rd_q) begin
                            go_q   <= 1'b1;
                            byte_q <= 8'h00;
                        end else begin
                            half_q <= par_half_q;
                        end
                    end
                end
                S_FETCH: begin
                    if (tx_valid) begin
                        byte_q     <= tx_data;
                        go_q       <= 1'b1;
                        len_left_q <= len_left_q - LEN_W'(1);
                    end
                end
                S_PARAM: ;
                S_RD: begin
                    if (sh_done) begin
                        raw_left_q <= raw_left_q - LEN_W'(1);
                        if (raw_left_q != LEN_W'(1)) go_q <= 1'b1;
                    end
                end
                S_END: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != S_IDLE);
        tx_ready  = (state_q == S_FETCH);
        spi_cs_n  = !(state_q == S_CMD || state_q == S_FETCH ||
                      state_q == S_PARAM || state_q == S_RD);
        spi_dcx   = !(state_q == S_CMD || state_q == S_RD);
        lcd_rst_n = (state_q != S_RST_LO);
        err       = err_q;
        rst_done  = done_q;
    end

    dbi_shifter #(.HALF_W(HALF_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (go_q),
        .half    (half_q),
        .tx_byte (byte_q),
        .miso    (spi_miso),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .done    (sh_done),
        .rx_byte (sh_rx)
    );

    dbi_rx_align u_align (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clr_q),
        .dummy    (dummy_q),
        .in_stb   (sh_done && state_q == S_RD),
        .in_byte  (sh_rx),
        .out_stb  (rx_valid),
        .out_byte (rx_data)
    );
endmodule

// File: rtl/dbi_spi_master_chk.sv
module dbi_spi_master_chk (
    input logic clk,
    input logic rst_n,
    input logic spi_cs_n,
    input logic spi_sclk,
    input logic spi_mosi,
    input logic spi_dcx,
    input logic busy,
    input logic err,
    input logic tx_ready,
    input logic rx_valid,
    input logic lcd_rst_n,
    input logic rst_done
);
    // R9
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);
    // R9
    mosi_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(spi_mosi) |-> !spi_sclk);
    // R5
    reject_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && spi_cs_n));
    // R6
    rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_rst_n |-> (spi_cs_n && busy));
    // R6
    rst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_done |-> (lcd_rst_n && !busy));
    // R10
    fetch_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> (!spi_cs_n && spi_dcx));
    // R8
    busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> busy);
    // R7
    cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> busy);
    // R3
    rx_in_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> busy);
endmodule

bind dbi_spi_master dbi_spi_master_chk u_chk (.*);

// File: tb/sim_dbi_spi_master.sv
`timescale 1ns/1ps
module sim_dbi_spi_master;
    localparam int LW = 16, CH = 3, PH = 1, RH = 5, SM = 64, RLO = 40, RWT = 90;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0, hwrst_req = 1'b0, req_valid = 1'b0, req_read = 1'b0;
    logic [7:0] req_op = '0, tx_data = '0;
    logic [LW-1:0] req_len = '0;
    logic tx_valid = 1'b1, spi_miso = 1'b0;
    logic tx_ready, rx_valid, busy, err, rst_done, spi_sclk, spi_mosi, spi_cs_n, spi_dcx, lcd_rst_n;
    logic [7:0] rx_data;

    dbi_spi_master #(.LEN_W(LW), .CMD_HALF(CH), .PIX_HALF(PH), .RD_HALF(RH),
        .SHORT_MAX(SM), .RST_LO_CYC(RLO), .RST_WAIT_CYC(RWT)) u0 (.*);

    int total = 0, bad = 0;
    bit finished = 0;
    logic [7:0] tx_q[$];
    logic [7:0] rx_q[$];
    bit resp_bits[$];
    int got_q[$];
    int tx_idx = 0, cs_falls = 0, inv_bad = 0, lo_cnt = 0, wait_cnt = 0, rise_idx = 0;
    bit rst_seen = 0, pend_rise = 0;
    logic prev_sclk = 0, prev_cs = 1, dcx_first = 0, mix = 0;
    logic [7:0] shreg = 0;
    int bitn = 0, hicnt = 0, hi_first = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural slave, stream driver and per-clock invariant model
    initial begin
        forever begin
            @(negedge clk);
            tx_data = (tx_idx < tx_q.size()) ? tx_q[tx_idx] : 8'h00;
            if (tx_ready) tx_idx++;
            if (spi_cs_n && spi_sclk) inv_bad++;
            if (!spi_cs_n && !busy) inv_bad++;
            if (pend_rise && busy) inv_bad++;
            pend_rise = !prev_cs && spi_cs_n;
            if (prev_cs && !spi_cs_n) begin
                cs_falls++; rise_idx = 0; bitn = 0; mix = 0;
            end
            if (!prev_sclk && spi_sclk) begin
                shreg = {shreg[6:0], spi_mosi};
                if (bitn == 0) dcx_first = spi_dcx;
                else if (spi_dcx != dcx_first) mix = 1;
                hicnt = 1;
                rise_idx++;
                spi_miso = (rise_idx >= 8 && rise_idx - 8 < resp_bits.size()) ?
                           resp_bits[rise_idx-8] : 1'b0;
            end else if (spi_sclk) hicnt++;
            if (prev_sclk && !spi_sclk) begin
                if (bitn == 0) hi_first = hicnt;
                else if (hicnt != hi_first) mix = 1;
                bitn++;
                if (bitn == 8) begin
                    got_q.push_back((int'(dcx_first) << 20) | (int'(mix) << 19) |
                                    (hi_first << 8) | int'(shreg));
                    bitn = 0; mix = 0;
                end
            end
            if (rx_valid) rx_q.push_back(rx_data);
            if (!lcd_rst_n) lo_cnt++;
            if (lcd_rst_n && busy && lo_cnt > 0 && !rst_seen) wait_cnt++;
            if (rst_done) rst_seen = 1;
            prev_sclk = spi_sclk;
            prev_cs = spi_cs_n;
        end
    end

    task automatic clear_all();
        tx_q.delete(); rx_q.delete(); resp_bits.delete(); got_q.delete();
        tx_idx = 0; cs_falls = 0; inv_bad = 0; lo_cnt = 0; wait_cnt = 0; rst_seen = 0;
    endtask

    task automatic issue(input logic [7:0] op, input int len, input bit rd);
        @(negedge clk);
        req_op = op; req_len = LW'(len); req_read = rd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] op, input int len, input int seed);
        int ph;
        clear_all();
        for (int i = 0; i < len; i++) tx_q.push_back(8'((i * 37 + seed) & 8'hFF));
        issue(op, len, 1'b0);
        ph = (len > SM) ? PH : CH;
        chk(got_q.size() == len + 1, "R10 byte count", got_q.size(), len + 1);
        chk(cs_falls == 1, "R7 single select", cs_falls, 1);
        chk(inv_bad == 0, "R8 busy/select/clock model", inv_bad, 0);
        if (got_q.size() == len + 1) begin
            chk(got_q[0] == ((CH << 8) | int'(op)), "R1 R2 R9 opcode byte", got_q[0], (CH << 8) | int'(op));
            for (int i = 0; i < len; i++) begin
                int e;
                e = (1 << 20) | (ph << 8) | int'(tx_q[i]);
                if (got_q[i+1] != e) chk(0, "R1 R2 R9 parameter byte", got_q[i+1], e);
            end
            chk(1, "R2 parameter bytes", 0, 0);
        end
    endtask

    task automatic do_read(input logic [7:0] op, input int len, input bit dmy, input logic [7:0] d[]);
        int nraw;
        clear_all();
        if (dmy) resp_bits.push_back(1'b1);
        foreach (d[i]) for (int b = 7; b >= 0; b--) resp_bits.push_back(d[i][b]);
        nraw = len + (dmy ? 1 : 0);
        while (resp_bits.size() < nraw * 8) resp_bits.push_back(1'b1);
        issue(op, len, 1'b1);
        chk(got_q.size() == nraw + 1, "R3 R4 raw byte count", got_q.size(), nraw + 1);
        chk(cs_falls == 1, "R7 single select", cs_falls, 1);
        chk(inv_bad == 0, "R8 busy/select/clock model", inv_bad, 0);
        if (got_q.size() == nraw + 1) begin
            chk(got_q[0] == ((RH << 8) | int'(op)), "R3 opcode at read rate", got_q[0], (RH << 8) | int'(op));
            for (int i = 1; i <= nraw; i++)
                if (got_q[i] != (RH << 8)) chk(0, "R3 response phase", got_q[i], RH << 8);
        end
        chk(rx_q.size() == len, "R3 R4 result count", rx_q.size(), len);
        if (rx_q.size() == len)
            for (int i = 0; i < len; i++)
                chk(rx_q[i] == d[i], dmy ? "R4 realigned byte" : "R3 response byte", rx_q[i], d[i]);
    endtask

    task automatic do_bad(input logic [7:0] op, input int len);
        clear_all();
        @(negedge clk);
        req_op = op; req_len = LW'(len); req_read = 1'b1; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(err == 1'b1 && busy == 1'b0, "R5 reject pulse", {err, busy}, 2);
        @(negedge clk);
        chk(err == 1'b0, "R5 single pulse", err, 0);
        repeat (10) @(negedge clk);
        chk(cs_falls == 0 && busy == 1'b0, "R5 no transfer", cs_falls, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({spi_cs_n, spi_sclk, busy, lcd_rst_n, spi_dcx, tx_ready} == 6'b100110,
            "R9 R1 reset state", {spi_cs_n, spi_sclk, busy, lcd_rst_n, spi_dcx, tx_ready}, 6'b100110);

        do_write(8'h29, 0, 0);          // R10 opcode only
        do_write(8'h2A, 4, 5);          // R1 short
        do_write(8'h2C, 64, 11);        // R2 boundary
        do_write(8'h2C, 65, 3);         // R2 long
        do_read(8'h0A, 2, 1'b0, '{8'h81, 8'h7E});          // R3
        do_read(8'h0C, 1, 1'b0, '{8'h5A});                 // R3
        do_read(8'h04, 3, 1'b1, '{8'hA5, 8'h3C, 8'hF0});   // R4
        do_read(8'h09, 4, 1'b1, '{8'h12, 8'hFE, 8'h01, 8'h80}); // R4
        do_bad(8'h0A, 0);               // R5 zero length
        do_bad(8'h04, 2);               // R5 bad id length
        do_bad(8'h09, 5);               // R5 bad status length

        clear_all();                    // R6
        @(negedge clk);
        hwrst_req = 1'b1;
        @(negedge clk);
        hwrst_req = 1'b0;
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(lo_cnt == RLO, "R6 low time", lo_cnt, RLO);
        chk(wait_cnt == RWT, "R6 wait time", wait_cnt, RWT);
        chk(rst_seen, "R6 done pulse", rst_seen, 1);
        chk(cs_falls == 0, "R6 no serial activity", cs_falls, 0);

        do_write(8'h36, 1, 7);          // R1 after reset
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule